// File: doc/BRIEF.md
# Memory-Indirect Execution Sequencer

This block carries out one already-decoded instruction on a machine that has no register file: every operand is a memory address, and every value lives in a single word-addressed memory. When `start` is pulsed, the sequencer captures the operation (a size flag, a 7-bit opcode, two 32-bit operand fields and the address of the following instruction). It first stores the following-instruction address into memory word 0, which acts as the program counter. It then follows zero, one or two pointer hops on the source operand and one or two on the destination, reads the current destination value when the operation needs it, combines the two, and writes the result back.

Jumps are ordinary writes to word 0. Because the program-counter update comes first, a taken jump, or any instruction whose destination is word 0, overrides normal sequencing. A pseudo system call hands a word to an external agent over a request/acknowledge pair and waits for the answer. Any memory access beyond the configured memory size, or an undefined opcode, parks the block in a fault state that only reset leaves.

Top module: `exec_seq`

## Requirements
- R1: Two-operand opcodes 0 to 5 are moves: 0 `*a=b`, 1 `*a=*b`, 2 `*a=**b`, 3 `**a=b`, 4 `**a=*b`, 5 `**a=**b`, where `*x` is the memory word at address x.
- R2: Two-operand opcodes 6 to 15 compute `*a = *a op s`, with op being AND (6,7), OR (8,9), add (10,11), subtract (12,13) or multiply (14,15). An even opcode uses s=b and an odd one uses s=*b. All arithmetic is unsigned and keeps the low 32 bits, and subtract equals `*a + 1 + ~s`.
- R3: One-operand opcode 0 replaces `*a` with its bitwise complement.
- R4: Two-operand opcodes 16/17 write the target into word 0 when `*a` is zero, and 18/19 do so when `*a` is nonzero. An even opcode takes the target b and an odd one takes `*b`. When the condition fails, word 0 keeps the next-instruction address.
- R5: The first memory write of every instruction stores `next_pc` into word 0, and every later read sees that value. The result write comes last. `done` is high for exactly the cycle of that final write.
- R6: One-operand opcode 1 raises `sys_req` with `sys_out = *a` and holds both steady until `sys_ack`. The value on `sys_in` in the acknowledge cycle is then written to `*a`.
- R7: Any read or write address at or above `MEM_WORDS` is never issued. The block enters a fault state instead, with no result write. In that state `fault` is high, `busy` and `done` are low, no memory access occurs and `start` is ignored. Only reset leaves it.
- R8: A two-operand opcode above 19, or a one-operand opcode above 1, raises `fault` without any memory write.
- R9: After reset, `busy`, `done`, `fault`, `mem_en` and `sys_req` are low, and while idle the block issues no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing the presented instruction (taken when idle) |
| is_binary | input | 1 | 1: two-operand instruction, 0: one-operand |
| opcode | input | 7 | Operation code within its size class |
| op_a | input | 32 | Left (destination) operand field |
| op_b | input | 32 | Right operand field |
| next_pc | input | 32 | Address of the following instruction |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final cycle of the instruction |
| fault | output | 1 | Sticky fault state |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| sys_req | output | 1 | System call request |
| sys_out | output | 32 | Word handed to the system call agent |
| sys_ack | input | 1 | System call answer present |
| sys_in | input | 32 | Answer from the system call agent |

## Verification
The bench builds the block with `DATA_W` of 32 and `MEM_WORDS` of 64, so a 64-word memory model surrounds it. With that size, both an operand field and a pointer fetched from memory can point past the end, which exercises the fault path from the source chain and from the destination chain. The full 32-bit width keeps wrap-around cases for add, subtract and multiply at their natural boundaries.

// File: rtl/exec_seq_pkg.sv
// Shared types for the memory-indirect execution sequencer.
// Assumes: opcodes are at most 7 bits and pointer depth is at most 2.
package exec_seq_pkg;

    typedef enum logic [3:0] {
        K_MOV, K_AND, K_OR, K_ADD, K_SUB, K_MUL, K_JZ, K_JNZ, K_NOT, K_SYS
    } kind_t;

    typedef struct packed {
        logic       valid;      // opcode is defined
        logic [1:0] src_depth;  // pointer hops on the right operand
        logic       dst_ind2;   // destination goes through one extra pointer
        logic       needs_old;  // current destination value is an input
        kind_t      kind;
    } plan_t;

endpackage

// File: rtl/exec_seq_decode.sv
// Maps size flag and opcode onto an execution plan.
// Assumes: undefined opcodes give valid=0, and all other fields are then don't-care.
module exec_seq_decode
    import exec_seq_pkg::*;
#(
    parameter int OP_W = 7
) (
    input  logic            is_binary,
    input  logic [OP_W-1:0] opcode,
    output plan_t           plan
);

    // Purpose: pick operand depths and operation class for the opcode.
    always_comb begin
        plan = '0;
        plan.kind = K_MOV;
        if (is_binary) begin
            if (opcode <= OP_W'(5)) begin
                plan.valid     = 1'b1;
                plan.dst_ind2  = (opcode >= OP_W'(3));
                plan.src_depth = plan.dst_ind2 ? 2'(opcode - OP_W'(3)) : 2'(opcode);
            end else if (opcode <= OP_W'(19)) begin
                plan.valid     = 1'b1;
                plan.needs_old = 1'b1;
                plan.src_depth = {1'b0, opcode[0]};
                case (opcode[4:1])
                    4'd3:    plan.kind = K_AND;
                    4'd4:    plan.kind = K_OR;
                    4'd5:    plan.kind = K_ADD;
                    4'd6:    plan.kind = K_SUB;
                    4'd7:    plan.kind = K_MUL;
                    4'd8:    plan.kind = K_JZ;
                    default: plan.kind = K_JNZ;
                endcase
            end
        end else if (opcode <= OP_W'(1)) begin
            plan.valid     = 1'b1;
            plan.needs_old = 1'b1;
            plan.kind      = opcode[0] ? K_SYS : K_NOT;
        end
    end

endmodule

// File: rtl/exec_seq_alu.sv
// Combines the destination value and the resolved source value.
// Assumes: for jumps the result is the target and 'take' gives the condition.
module exec_seq_alu
    import exec_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  kind_t             kind,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] result,
    output logic              take
);

    // Purpose: evaluate the operation with wrap-around unsigned arithmetic.
    always_comb begin
        take = 1'b0;
        case (kind)
            K_AND:   result = lhs & rhs;
            K_OR:    result = lhs | rhs;
            K_ADD:   result = lhs + rhs;
            K_SUB:   result = lhs + DATA_W'(1) + ~rhs;
            K_MUL:   result = lhs * rhs;
            K_NOT:   result = ~lhs;
            K_SYS:   result = lhs;
            K_JZ: begin
                result = rhs;
                take   = (lhs == '0);
            end
            K_JNZ: begin
                result = rhs;
                take   = (lhs != '0);
            end
            default: result = rhs;
        endcase
    end

endmodule

// File: rtl/exec_seq.sv
// Runs one decoded instruction entirely through memory: it writes the program
// counter word 0, resolves pointer chains, reads the destination, computes and
// writes back. Assumes a single-port memory whose read data arrives one cycle
// after the request, and a word address space of MEM_WORDS words.
module exec_seq
    import exec_seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int OP_W      = 7,
    parameter int MEM_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_binary,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] next_pc,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sys_req,
    output logic [DATA_W-1:0] sys_out,
    input  logic              sys_ack,
    input  logic [DATA_W-1:0] sys_in
);

    localparam logic [DATA_W-1:0] MEM_LIMIT = DATA_W'(MEM_WORDS);

    typedef enum logic [3:0] {
        S_IDLE, S_PCW, S_SRC, S_SRCW, S_DST, S_DSTW,
        S_OLD, S_OLDW, S_SYS, S_WB, S_FAULT
    } state_t;

    state_t            state, nxt;
    plan_t             dec, plan_q;
    logic [DATA_W-1:0] a_q, val_q, dst_q, old_q, npc_q;
    logic [1:0]        hops_q;
    logic [DATA_W-1:0] result;
    logic              take;
    logic              is_jump;

    function automatic logic in_rng(input logic [DATA_W-1:0] x);
        return x < MEM_LIMIT;
    endfunction

    exec_seq_decode #(.OP_W(OP_W)) u_decode (
        .is_binary (is_binary),
        .opcode    (opcode),
        .plan      (dec)
    );

    exec_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .kind   (plan_q.kind),
        .lhs    (old_q),
        .rhs    (val_q),
        .result (result),
        .take   (take)
    );

    assign is_jump = (plan_q.kind == K_JZ) || (plan_q.kind == K_JNZ);
    assign busy    = (state != S_IDLE) && (state != S_FAULT);
    assign fault   = (state == S_FAULT);
    assign sys_req = (state == S_SYS);
    assign sys_out = old_q;

    // Purpose: next state and memory request for the current step.
    always_comb begin
        nxt       = state;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        case (state)
            S_IDLE: if (start) nxt = dec.valid ? S_PCW : S_FAULT;
            S_PCW: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = npc_q;
                nxt       = S_SRC;
            end
            S_SRC: begin
                if (hops_q == 2'd0) nxt = S_DST;
                else if (in_rng(val_q)) begin
                    mem_en   = 1'b1;
                    mem_addr = val_q;
                    nxt      = S_SRCW;
                end else nxt = S_FAULT;
            end
            S_SRCW: nxt = S_SRC;
            S_DST: begin
                if (!plan_q.dst_ind2) nxt = plan_q.needs_old ? S_OLD : S_WB;
                else if (in_rng(a_q)) begin
                    mem_en   = 1'b1;
                    mem_addr = a_q;
                    nxt      = S_DSTW;
                end else nxt = S_FAULT;
            end
            S_DSTW: nxt = plan_q.needs_old ? S_OLD : S_WB;
            S_OLD: begin
                if (in_rng(dst_q)) begin
                    mem_en   = 1'b1;
                    mem_addr = dst_q;
                    nxt      = S_OLDW;
                end else nxt = S_FAULT;
            end
            S_OLDW: nxt = (plan_q.kind == K_SYS) ? S_SYS : S_WB;
            S_SYS: if (sys_ack) nxt = S_WB;
            S_WB: begin
                if (is_jump) begin
                    done      = 1'b1;
                    mem_en    = take;
                    mem_we    = take;
                    mem_wdata = result;
                    nxt       = S_IDLE;
                end else if (in_rng(dst_q)) begin
                    done      = 1'b1;
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dst_q;
                    mem_wdata = result;
                    nxt       = S_IDLE;
                end else nxt = S_FAULT;
            end
            S_FAULT: nxt = S_FAULT;
            default: nxt = S_IDLE;
        endcase
    end

    // Purpose: advance the state and capture operands and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            plan_q <= '0;
            a_q    <= '0;
            val_q  <= '0;
            dst_q  <= '0;
            old_q  <= '0;
            npc_q  <= '0;
            hops_q <= '0;
        end else begin
            state <= nxt;
            case (state)
                S_IDLE: if (start) begin
                    plan_q <= dec;
                    a_q    <= op_a;
                    val_q  <= op_b;
                    npc_q  <= next_pc;
                    hops_q <= dec.src_depth;
                end
                S_SRCW: begin
                    val_q  <= mem_rdata;
                    hops_q <= hops_q - 2'd1;
                end
                S_DST:  if (!plan_q.dst_ind2) dst_q <= a_q;
                S_DSTW: dst_q <= mem_rdata;
                S_OLDW: old_q <= mem_rdata;
                S_SYS:  if (sys_ack) old_q <= sys_in;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exec_seq_chk.sv
// Protocol checker for exec_seq, attached through bind.
// Assumes it sees the top-level ports only.
module exec_seq_chk #(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] next_pc,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              mem_en,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              sys_req,
    input logic [DATA_W-1:0] sys_out,
    input logic              sys_ack
);

    logic              wrote;
    logic [DATA_W-1:0] npc_l;

    // Purpose: remember the next-pc of the accepted instruction and whether it wrote yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote <= 1'b0;
            npc_l <= '0;
        end else begin
            if (!busy && !fault && start) npc_l <= next_pc;
            if (!busy) wrote <= 1'b0;
            else if (mem_we) wrote <= 1'b1;
        end
    end

    // R5: the first write of an instruction stores next_pc into word 0
    p_pc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mem_we && !wrote |-> mem_addr == '0 && mem_wdata == npc_l);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> mem_addr < DATA_W'(MEM_WORDS));

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_en && !done && !busy);

    p_sys_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req && !sys_ack |=> sys_req && $stable(sys_out));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en && !sys_req && !done);

    p_we_has_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

endmodule

bind exec_seq exec_seq_chk #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .next_pc(next_pc),
    .busy(busy), .done(done), .fault(fault), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sys_req(sys_req), .sys_out(sys_out), .sys_ack(sys_ack)
);

// File: tb/exec_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for exec_seq with a 64-word memory model and a system call responder.
module exec_seq_bench;

    localparam int DW = 32;
    localparam int MW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_binary = 1'b0;
    logic [6:0]    opcode = '0;
    logic [DW-1:0] op_a = '0, op_b = '0, next_pc = '0;
    logic          busy, done, fault, mem_en, mem_we, sys_req;
    logic [DW-1:0] mem_addr, mem_wdata, sys_out;
    logic [DW-1:0] mem_rdata = '0;
    logic          sys_ack = 1'b0;
    logic [DW-1:0] sys_in = '0;
    logic [DW-1:0] mem [MW];
    int            total = 0, bad = 0, cycles = 0, ack_cnt = 0;
    logic [DW-1:0] sys_seen = '0;
    logic          sys_moved = 1'b0;

    always #2 clk = ~clk;

    exec_seq #(.DATA_W(DW), .OP_W(7), .MEM_WORDS(MW)) u_exec_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_binary(is_binary),
        .opcode(opcode), .op_a(op_a), .op_b(op_b), .next_pc(next_pc),
        .busy(busy), .done(done), .fault(fault), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sys_req(sys_req), .sys_out(sys_out),
        .sys_ack(sys_ack), .sys_in(sys_in)
    );

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= mem[mem_addr[5:0]];
            if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
        end
    end

    // System call responder: answers three cycles after the request with sys_out + 0x100
    always @(posedge clk) begin
        if (!rst_n || sys_ack) begin
            sys_ack <= 1'b0;
            ack_cnt <= 0;
        end else if (sys_req) begin
            if (ack_cnt == 3) begin
                sys_ack <= 1'b1;
                sys_in  <= sys_out + 32'h100;
            end
            ack_cnt <= ack_cnt + 1;
        end
    end

    // Records what sys_out shows while a request is pending
    always @(negedge clk) begin
        if (sys_req) begin
            if (ack_cnt > 0 && sys_out != sys_seen) sys_moved <= 1'b1;
            sys_seen <= sys_out;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic bin, input logic [6:0] op,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] npc);
        @(negedge clk);
        is_binary = bin; opcode = op; op_a = a; op_b = b; next_pc = npc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (done || fault) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 busy", {31'b0, busy}, 32'd0);
        chk("R9 fault", {31'b0, fault}, 32'd0);
        chk("R9 mem_en/sys_req/done", {29'b0, mem_en, sys_req, done}, 32'd0);
    endtask

    task automatic t_moves();
        mem[20] = 32'hCAFE; mem[21] = 32'd20; mem[22] = 32'd30;
        run(1'b1, 7'd0, 32'd10, 32'h1234, 32'd7);
        chk("R1 mov10", mem[10], 32'h1234);
        chk("R5 pc after mov10", mem[0], 32'd7);
        run(1'b1, 7'd1, 32'd11, 32'd20, 32'd8);
        chk("R1 mov11", mem[11], 32'hCAFE);
        run(1'b1, 7'd2, 32'd12, 32'd21, 32'd9);
        chk("R1 mov12", mem[12], 32'hCAFE);
        run(1'b1, 7'd3, 32'd22, 32'h55, 32'd10);
        chk("R1 mov20", mem[30], 32'h55);
        mem[20] = 32'hBEEF;
        run(1'b1, 7'd4, 32'd22, 32'd20, 32'd11);
        chk("R1 mov21", mem[30], 32'hBEEF);
        mem[20] = 32'h600D;
        run(1'b1, 7'd5, 32'd22, 32'd21, 32'd12);
        chk("R1 mov22", mem[30], 32'h600D);
    endtask

    task automatic t_alu();
        mem[40] = 32'hFFFF_FFF0;
        run(1'b1, 7'd10, 32'd40, 32'h20, 32'd1);
        chk("R2 add10 wrap", mem[40], 32'h10);
        mem[40] = 32'd3; mem[41] = 32'd4;
        run(1'b1, 7'd11, 32'd40, 32'd41, 32'd1);
        chk("R2 add11", mem[40], 32'd7);
        mem[40] = 32'd5; mem[41] = 32'd7;
        run(1'b1, 7'd13, 32'd40, 32'd41, 32'd1);
        chk("R2 sub11 wrap", mem[40], 32'hFFFF_FFFE);
        mem[40] = 32'd100;
        run(1'b1, 7'd12, 32'd40, 32'd1, 32'd1);
        chk("R2 sub10", mem[40], 32'd99);
        mem[40] = 32'hF0F0;
        run(1'b1, 7'd6, 32'd40, 32'hFF00, 32'd1);
        chk("R2 and10", mem[40], 32'hF000);
        mem[40] = 32'hF0F0; mem[41] = 32'h0F0F;
        run(1'b1, 7'd9, 32'd40, 32'd41, 32'd1);
        chk("R2 or11", mem[40], 32'hFFFF);
        mem[40] = 32'h1_0000;
        run(1'b1, 7'd14, 32'd40, 32'h1_0000, 32'd1);
        chk("R2 mul10 wrap", mem[40], 32'd0);
        mem[40] = 32'd7; mem[41] = 32'd6;
        run(1'b1, 7'd15, 32'd40, 32'd41, 32'd1);
        chk("R2 mul11", mem[40], 32'd42);
    endtask

    task automatic t_not();
        mem[42] = 32'h0F0F_0000;
        run(1'b0, 7'd0, 32'd42, 32'd0, 32'd3);
        chk("R3 not1", mem[42], 32'hF0F0_FFFF);
    endtask

    task automatic t_jumps();
        mem[43] = 32'd0; mem[44] = 32'h77;
        run(1'b1, 7'd16, 32'd43, 32'h29, 32'd8);
        chk("R4 jz10 taken", mem[0], 32'h29);
        mem[43] = 32'd1;
        run(1'b1, 7'd16, 32'd43, 32'h29, 32'd8);
        chk("R4 jz10 not taken", mem[0], 32'd8);
        run(1'b1, 7'd19, 32'd43, 32'd44, 32'd9);
        chk("R4 jnz11 taken", mem[0], 32'h77);
        mem[43] = 32'd0;
        run(1'b1, 7'd19, 32'd43, 32'd44, 32'd9);
        chk("R4 jnz11 not taken", mem[0], 32'd9);
        run(1'b1, 7'd17, 32'd43, 32'd44, 32'd5);
        chk("R4 jz11 taken", mem[0], 32'h77);
        chk("R4 jump leaves a", mem[43], 32'd0);
    endtask

    task automatic t_pc_word();
        mem[0] = 32'd2;
        run(1'b1, 7'd10, 32'd0, 32'd5, 32'd100);
        chk("R5 add10 on word 0", mem[0], 32'd105);
        run(1'b1, 7'd1, 32'd13, 32'd0, 32'd55);
        chk("R5 read of word 0", mem[13], 32'd55);
    endtask

    task automatic t_sys();
        mem[45] = 32'h10;
        run(1'b0, 7'd1, 32'd45, 32'd0, 32'd4);
        chk("R6 sys value out", sys_seen, 32'h10);
        chk("R6 sys_out steady", {31'b0, sys_moved}, 32'd0);
        chk("R6 sys result", mem[45], 32'h110);
    endtask

    task automatic t_range();
        mem[10] = 32'hAAAA;
        run(1'b1, 7'd1, 32'd10, 32'd100, 32'd9);
        chk("R7 fault on src", {31'b0, fault}, 32'd1);
        chk("R7 no result write", mem[10], 32'hAAAA);
        run(1'b1, 7'd0, 32'd10, 32'hDEAD, 32'd9);
        chk("R7 start ignored", mem[10], 32'hAAAA);
        chk("R7 still faulted", {30'b0, fault, busy}, 32'd2);
        do_reset();
        chk("R7 reset clears", {31'b0, fault}, 32'd0);
        mem[22] = 32'd200;
        run(1'b1, 7'd3, 32'd22, 32'd1, 32'd9);
        chk("R7 fault on dst pointer", {31'b0, fault}, 32'd1);
        do_reset();
    endtask

    task automatic t_opcode();
        mem[0] = 32'h1111;
        run(1'b1, 7'd20, 32'd10, 32'd1, 32'd9);
        chk("R8 bad binary opcode", {31'b0, fault}, 32'd1);
        chk("R8 no pc write", mem[0], 32'h1111);
        do_reset();
        run(1'b0, 7'd2, 32'd10, 32'd1, 32'd9);
        chk("R8 bad unary opcode", {31'b0, fault}, 32'd1);
        do_reset();
    endtask

    initial begin
        for (int i = 0; i < MW; i++) mem[i] = '0;
        t_reset();
        t_moves();
        t_alu();
        t_not();
        t_jumps();
        t_pc_word();
        t_sys();
        t_range();
        t_opcode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule